// File: doc/BRIEF.md
# Configuration RAM and Flash Page Controller

This block owns a 128-byte configuration RAM split into eight banks of sixteen bytes, and a nonvolatile store of 32 pages that it models internally. Each page is exactly as large as the whole RAM. A host reaches the RAM one byte at a time through a pointer that advances by itself after every read or write. The pointer runs straight across bank boundaries and wraps at the top of the RAM.

Three page commands move or inspect data. A store erases the chosen page and then programs the whole RAM into it. A load copies the chosen page over every RAM byte. A checksum adds up the bytes of a page. Stores are accepted only when both the write-enable pin and the write-enable register bit are set.

After reset the block copies page 0 into the RAM and then latches bank 0 into a 16-byte configuration register set, so the stored page 0 sets the power-up configuration. A busy flag covers every transfer. A separate flash-activity flag lets neighbouring logic discard conversion results taken while the store is being accessed.

Top module: `cfg_flash_ctrl`

## Requirements
- R1: A RAM address is 7 bits. Bits [6:4] select the bank and bits [3:0] the offset within it, so address 0x14 is bank 1, offset 4. `host_ptr_ld` loads the pointer from `host_addr`, and `host_rdata` always shows the byte at the pointer.
- R2: When idle, each `host_wr` (which writes `host_wdata` at the pointer) or `host_rd` advances the pointer by one, carrying across banks, so 0x0F is followed by 0x10. `host_ptr_ld` takes priority over `host_wr`, and `host_wr` over `host_rd`.
- R3: The pointer wraps from 0x7F (bank 7, offset 0xF) to 0x00.
- R4: A store command (`cmd_op` = 2'b01) erases the page named by `cmd_page` and then programs all 128 RAM bytes into it, with RAM address k going to page byte k.
- R5: A load command (`cmd_op` = 2'b10) overwrites all 128 RAM bytes with the selected page.
- R6: After reset, page 0 is copied into the RAM, and then RAM bank 0 (addresses 0x00 to 0x0F) is latched into `cfg_regs`, with byte k at bits [8k+7:8k]. The pointer resets to 0x00.
- R7: A store is ignored when `wren_pin` or `wren_bit` is low. In that case busy does not rise, `done` does not pulse and the page keeps its data.
- R8: A checksum command (`cmd_op` = 2'b11) places the modulo-256 sum of the page's 128 bytes on `cksum` and pulses `done`. The store starts fully erased and erased bytes read 0xFF, so an erased page sums to 0x80.
- R9: `busy` is high from the clock edge that accepts a command until the transfer ends. `done` then pulses for one cycle. Commands presented while busy are ignored and are not queued.
- R10: Host pointer loads, writes and reads are ignored while busy.
- R11: `flash_active` is high during the page 0 boot read, erase, program, load and checksum cycles. It is low when idle and during the one-cycle register latch at boot.
- R12: Busy lasts ERASE_CYC + 128 cycles for a store, 128 cycles for a load or checksum, and 129 cycles for the boot sequence counted from reset release. The default ERASE_CYC is 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the boot sequence |
| host_ptr_ld | input | 1 | Load the RAM pointer from host_addr |
| host_addr | input | 7 | Linear RAM address {bank, offset} |
| host_wr | input | 1 | Write host_wdata at the pointer, then advance |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Consume the byte at the pointer, then advance |
| host_rdata | output | 8 | RAM byte at the pointer |
| host_ptr | output | 7 | Current pointer value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 store, 10 load, 11 checksum |
| cmd_page | input | 5 | Page selected by the command |
| wren_pin | input | 1 | Write-enable pin |
| wren_bit | input | 1 | Write-enable register bit |
| busy | output | 1 | Transfer or boot in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| flash_active | output | 1 | The page store is being read, erased or programmed |
| cksum | output | 8 | Result of the last checksum command |
| cfg_regs | output | 128 | Configuration registers latched from bank 0 at boot |

## Verification
The in-line assertions check, on every cycle, that the pointer moves by exactly one and wraps at the top address, that it holds still while busy, and that a protected store leaves the sequencer idle. They also check that `done` is a single-cycle pulse, that programming always follows an erase, and that flash activity never appears outside busy. The data moved between RAM and pages, the checksum values, the exact busy and flash-activity cycle counts, and the boot image that lands in `cfg_regs` after a reset can only be shown by the directed scenarios, which compare the values read back against patterns the bench computes itself.

// File: rtl/cfg_flash_pkg.sv
// Shared types for the configuration RAM / page store controller.
// Assumes the command encoding below is fixed by the external decoder.
package cfg_flash_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_STORE = 2'b01,
        OP_LOAD  = 2'b10,
        OP_SUM   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_BOOT, S_CFG, S_IDLE, S_ERASE, S_PROG, S_READ, S_SUM
    } seq_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_ram.sv
// Linear configuration RAM with a self-advancing host pointer and a
// second port for the page sequencer. Bank 0 is exposed flat.
// Assumes the host and sequencer ports are never active together
// (the top gates host strobes while busy).
module cfg_ram #(
    parameter int DATA_W = 8,
    parameter int BANKS  = 8,
    parameter int DEPTH  = 16,
    localparam int BYTES  = BANKS * DEPTH,
    localparam int ADDR_W = $clog2(BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ptr_ld,
    input  logic [ADDR_W-1:0]       ptr_addr,
    input  logic                    h_wr,
    input  logic [DATA_W-1:0]       h_wdata,
    input  logic                    h_rd,
    output logic [DATA_W-1:0]       h_rdata,
    output logic [ADDR_W-1:0]       ptr,
    input  logic                    s_we,
    input  logic [ADDR_W-1:0]       s_addr,
    input  logic [DATA_W-1:0]       s_wdata,
    output logic [DATA_W-1:0]       s_rdata,
    output logic [DEPTH*DATA_W-1:0] bank0
);
    logic [DATA_W-1:0] mem [BYTES];

    // Pointer: load wins, otherwise step after every host access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_ld)
            ptr <= ptr_addr;
        else if (h_wr || h_rd)
            ptr <= ptr + 1'b1;
    end

    // Array write: the sequencer and host writes share one port.
    always_ff @(posedge clk) begin
        if (s_we)
            mem[s_addr] <= s_wdata;
        else if (h_wr && !ptr_ld)
            mem[ptr] <= h_wdata;
    end

    assign h_rdata = mem[ptr];
    assign s_rdata = mem[s_addr];

    for (genvar k = 0; k < DEPTH; k++) begin : g_bank0
        assign bank0[k*DATA_W +: DATA_W] = mem[k];
    end

    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_ld && (h_wr || h_rd)) |=> ptr == $past(ptr) + 1'b1);
    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_ld && (h_wr || h_rd) && ptr == ADDR_W'(BYTES-1)) |=> ptr == '0);
endmodule

// File: rtl/cfg_page_store.sv
// Behavioural page-organised nonvolatile array. It comes up fully
// erased, erases one whole page in a single cycle and programs one
// byte per cycle. It is not cleared by reset.
module cfg_page_store #(
    parameter int DATA_W = 8,
    parameter int PAGES  = 32,
    parameter int BYTES  = 128,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int OFF_W  = $clog2(BYTES),
    localparam int FA_W   = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              erase,
    input  logic [PAGE_W-1:0] erase_page,
    input  logic              prog,
    input  logic [FA_W-1:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [PAGES*BYTES];

    // Models an array delivered in the erased state.
    initial begin
        for (int i = 0; i < PAGES*BYTES; i++) mem[i] = DATA_W'(cfg_flash_pkg::ERASED_BYTE);
    end

    // Page erase or byte program; erase takes precedence.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < BYTES; i++)
                mem[{erase_page, OFF_W'(i)}] <= DATA_W'(cfg_flash_pkg::ERASED_BYTE);
        end else if (prog) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/cfg_page_seq.sv
// Page transfer sequencer: runs the boot load, store (erase then
// program), load and checksum walks, one byte per cycle.
// Assumes cmd_op is meaningful only with cmd_valid.
module cfg_page_seq
    import cfg_flash_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PAGES     = 32,
    parameter int BYTES     = 128,
    parameter int ERASE_CYC = 24,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int OFF_W  = $clog2(BYTES),
    localparam int WC_W   = $clog2(ERASE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              wr_allow,
    output logic              busy,
    output logic              done,
    output logic              flash_active,
    output logic [DATA_W-1:0] cksum,
    output logic              cfg_load,
    output logic              ram_we,
    output logic [OFF_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              fl_erase,
    output logic              fl_prog,
    output logic [PAGE_W-1:0] fl_page,
    output logic [PAGE_W+OFF_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata
);
    seq_state_e        state;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  idx;
    logic [WC_W-1:0]   wcnt;
    logic [DATA_W-1:0] acc;
    logic              last;

    assign last         = (idx == OFF_W'(BYTES-1));
    assign busy         = (state != S_IDLE);
    assign flash_active = (state inside {S_BOOT, S_ERASE, S_PROG, S_READ, S_SUM});
    assign cfg_load     = (state == S_CFG);
    assign ram_we       = (state == S_BOOT) || (state == S_READ);
    assign ram_addr     = idx;
    assign ram_wdata    = fl_rdata;
    assign fl_page      = page;
    assign fl_addr      = {page, idx};
    assign fl_wdata     = ram_rdata;
    assign fl_prog      = (state == S_PROG);
    assign fl_erase     = (state == S_ERASE) && (wcnt == WC_W'(ERASE_CYC-1));

    // Sequencer state, byte walk, erase timer and checksum accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_BOOT;
            page  <= '0;
            idx   <= '0;
            wcnt  <= '0;
            acc   <= '0;
            cksum <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_BOOT: begin
                    idx <= idx + 1'b1;
                    if (last) state <= S_CFG;
                end
                S_CFG: state <= S_IDLE;
                S_IDLE: if (cmd_valid) begin
                    page <= cmd_page;
                    idx  <= '0;
                    wcnt <= '0;
                    acc  <= '0;
                    if (cmd_op == OP_STORE && wr_allow) state <= S_ERASE;
                    else if (cmd_op == OP_LOAD)         state <= S_READ;
                    else if (cmd_op == OP_SUM)          state <= S_SUM;
                end
                S_ERASE: begin
                    wcnt <= wcnt + 1'b1;
                    if (fl_erase) state <= S_PROG;
                end
                S_PROG, S_READ: begin
                    idx <= idx + 1'b1;
                    if (last) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                S_SUM: begin
                    acc <= acc + fl_rdata;
                    idx <= idx + 1'b1;
                    if (last) begin
                        cksum <= acc + fl_rdata;
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && cmd_op == OP_STORE && !wr_allow) |=> state == S_IDLE);
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && (cmd_op == OP_LOAD || cmd_op == OP_SUM)) |=> busy);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_erase_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && $past(state) != S_PROG) |-> $past(state) == S_ERASE);
    p_flash_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_active |-> busy);
endmodule

// File: rtl/cfg_flash_ctrl.sv
// Top: configuration RAM, page store and sequencer. Host RAM strobes
// are dropped while busy; bank 0 is latched into cfg_regs at boot.
// Assumes host strobes are single-cycle requests from a decoder.
module cfg_flash_ctrl #(
    parameter int DATA_W    = 8,
    parameter int BANKS     = 8,
    parameter int DEPTH     = 16,
    parameter int PAGES     = 32,
    parameter int ERASE_CYC = 24,
    localparam int BYTES  = BANKS * DEPTH,
    localparam int ADDR_W = $clog2(BYTES),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int CFG_W  = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ptr_ld,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] host_ptr,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              wren_pin,
    input  logic              wren_bit,
    output logic              busy,
    output logic              done,
    output logic              flash_active,
    output logic [DATA_W-1:0] cksum,
    output logic [CFG_W-1:0]  cfg_regs
);
    logic              cfg_load, s_we, fl_erase, fl_prog;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata, s_rdata, fl_wdata, fl_rdata;
    logic [PAGE_W-1:0] fl_page;
    logic [PAGE_W+ADDR_W-1:0] fl_addr;
    logic [CFG_W-1:0]  bank0;

    cfg_ram #(.DATA_W(DATA_W), .BANKS(BANKS), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .ptr_ld(host_ptr_ld && !busy), .ptr_addr(host_addr),
        .h_wr(host_wr && !busy), .h_wdata(host_wdata),
        .h_rd(host_rd && !busy), .h_rdata(host_rdata), .ptr(host_ptr),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .bank0(bank0)
    );

    cfg_page_store #(.DATA_W(DATA_W), .PAGES(PAGES), .BYTES(BYTES)) u_store (
        .clk(clk), .erase(fl_erase), .erase_page(fl_page), .prog(fl_prog),
        .addr(fl_addr), .wdata(fl_wdata), .rdata(fl_rdata)
    );

    cfg_page_seq #(.DATA_W(DATA_W), .PAGES(PAGES), .BYTES(BYTES),
                   .ERASE_CYC(ERASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
        .wr_allow(wren_pin && wren_bit),
        .busy(busy), .done(done), .flash_active(flash_active), .cksum(cksum),
        .cfg_load(cfg_load),
        .ram_we(s_we), .ram_addr(s_addr), .ram_wdata(s_wdata), .ram_rdata(s_rdata),
        .fl_erase(fl_erase), .fl_prog(fl_prog), .fl_page(fl_page),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    // Configuration register set, loaded once from bank 0 during boot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_regs <= '0;
        else if (cfg_load)
            cfg_regs <= bank0;
    end

    p_host_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(host_ptr));
    p_cfg_only_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cfg_regs));
endmodule

// File: tb/cfg_flash_ctrl_tb.sv
module cfg_flash_ctrl_tb;
    localparam int ERASE_CYC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_ptr_ld = 0, host_wr = 0, host_rd = 0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [6:0] host_ptr;
    logic       cmd_valid = 0;
    logic [1:0] cmd_op = '0;
    logic [4:0] cmd_page = '0;
    logic       wren_pin = 1, wren_bit = 1;
    logic       busy, done, flash_active;
    logic [7:0] cksum;
    logic [127:0] cfg_regs;

    int n_tests = 0, n_fail = 0;
    int bcyc, fcyc;
    bit done_seen;

    always #5 clk = ~clk;

    cfg_flash_ctrl #(.ERASE_CYC(ERASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_ptr_ld(host_ptr_ld), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_ptr(host_ptr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .wren_pin(wren_pin), .wren_bit(wren_bit),
        .busy(busy), .done(done), .flash_active(flash_active),
        .cksum(cksum), .cfg_regs(cfg_regs)
    );

    function automatic logic [7:0] pat_a(int i); return 8'(i*7 + 3); endfunction
    function automatic logic [7:0] pat_b(int i); return 8'(i) ^ 8'h5A; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [6:0] a);
        @(negedge clk); host_ptr_ld = 1; host_addr = a;
        @(negedge clk); host_ptr_ld = 0;
    endtask
    task automatic wr(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask
    task automatic rd();
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
    endtask

    // Count busy and flash-active cycles from the current negedge on.
    task automatic wait_idle();
        bcyc = 0; fcyc = 0;
        while (busy) begin
            bcyc++;
            if (flash_active) fcyc++;
            @(negedge clk);
        end
        done_seen = done;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [4:0] pg);
        @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_page = pg;
        @(negedge clk); cmd_valid = 0; cmd_op = 2'b00;
        wait_idle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        chk(busy == 1 && done == 0, "R9 busy/done in reset", {busy, done}, 2'b10);
        rst_n = 1;
        wait_idle();
    endtask

    task automatic fill(input int kind);
        set_ptr(7'h00);
        for (int i = 0; i < 128; i++)
            wr(kind == 0 ? 8'h00 : (kind == 1 ? pat_a(i) : pat_b(i)));
    endtask

    // Reads the whole RAM from 0 and counts bytes that differ from the pattern.
    task automatic dump_cmp(input int kind, input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        set_ptr(7'h00);
        for (int i = 0; i < 128; i++) begin
            logic [7:0] e;
            e = kind == 0 ? 8'h00 : (kind == 1 ? pat_a(i) : (kind == 2 ? pat_b(i) : 8'hFF));
            if (host_rdata !== e) begin
                if (bad == 0) begin first_act = host_rdata; first_exp = e; end
                bad++;
            end
            rd();
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk(bcyc == 129, "R12 boot busy cycles", bcyc, 129);
        chk(fcyc == 128, "R11 boot flash_active cycles", fcyc, 128);
        chk(cfg_regs == {16{8'hFF}}, "R6 cfg from erased page 0", cfg_regs[7:0], 8'hFF);
        chk(host_ptr == 0 && host_rdata == 8'hFF, "R6 pointer/ram after boot",
            {host_ptr, host_rdata}, {7'h0, 8'hFF});
        chk(flash_active == 0 && done == 0, "R11 idle flags", {flash_active, done}, 0);
    endtask

    task automatic t_linear();
        set_ptr(7'h10);
        for (int k = 0; k < 16; k++) wr(8'h40 + 8'(k));
        set_ptr(7'h14);
        chk(host_rdata == 8'h44, "R1 bank1 offset4", host_rdata, 8'h44);
        set_ptr(7'h0E);
        wr(8'hA1); wr(8'hB2); wr(8'hC3); wr(8'hD4);
        chk(host_ptr == 7'h12, "R2 pointer after 4 writes", host_ptr, 7'h12);
        set_ptr(7'h0F);
        chk(host_rdata == 8'hB2, "R2 byte at 0x0F", host_rdata, 8'hB2);
        rd();
        chk(host_ptr == 7'h10 && host_rdata == 8'hC3, "R2 bank carry on read",
            {host_ptr, host_rdata}, {7'h10, 8'hC3});
        @(negedge clk); host_ptr_ld = 1; host_addr = 7'h20; host_wr = 1; host_wdata = 8'hEE;
        @(negedge clk); host_ptr_ld = 0; host_wr = 0;
        chk(host_ptr == 7'h20, "R2 load wins over write", host_ptr, 7'h20);
    endtask

    task automatic t_wrap();
        set_ptr(7'h7E);
        wr(8'h11); wr(8'h22); wr(8'h33);
        chk(host_ptr == 7'h01, "R3 wrap on write", host_ptr, 7'h01);
        set_ptr(7'h7F);
        chk(host_rdata == 8'h22, "R3 byte at 0x7F", host_rdata, 8'h22);
        rd();
        chk(host_ptr == 7'h00 && host_rdata == 8'h33, "R3 wrap on read",
            {host_ptr, host_rdata}, {7'h00, 8'h33});
    endtask

    task automatic t_store_load();
        fill(1);
        chk(host_ptr == 7'h00, "R3 full-ram wrap", host_ptr, 0);
        run_cmd(2'b01, 5'd5);
        chk(bcyc == ERASE_CYC + 128, "R12 store busy cycles", bcyc, ERASE_CYC + 128);
        chk(fcyc == ERASE_CYC + 128, "R11 store flash_active", fcyc, ERASE_CYC + 128);
        chk(done_seen, "R9 store done pulse", done_seen, 1);
        @(negedge clk);
        chk(done == 0, "R9 done single cycle", done, 0);
        fill(0);
        run_cmd(2'b10, 5'd5);
        chk(bcyc == 128 && fcyc == 128, "R12 load busy cycles", bcyc, 128);
        chk(done_seen, "R5 load done", done_seen, 1);
        dump_cmp(1, "R5 ram after load page 5");
        fill(2);
        run_cmd(2'b01, 5'd5);
        run_cmd(2'b10, 5'd5);
        dump_cmp(2, "R4 overwrite of programmed page");
    endtask

    task automatic t_checksum();
        logic [7:0] e = 0;
        for (int i = 0; i < 128; i++) e += pat_b(i);
        run_cmd(2'b11, 5'd5);
        chk(cksum == e && done_seen, "R8 checksum page 5", cksum, e);
        chk(bcyc == 128 && fcyc == 128, "R12 checksum busy cycles", bcyc, 128);
        run_cmd(2'b11, 5'd9);
        chk(cksum == 8'h80, "R8 checksum erased page", cksum, 8'h80);
    endtask

    task automatic t_protect();
        logic [7:0] e = 0;
        for (int i = 0; i < 128; i++) e += pat_b(i);
        fill(0);
        wren_pin = 0;
        run_cmd(2'b01, 5'd5);
        chk(bcyc == 0 && !done_seen, "R7 pin low ignored", {bcyc, done_seen}, 0);
        wren_pin = 1; wren_bit = 0;
        run_cmd(2'b01, 5'd5);
        chk(bcyc == 0 && !done_seen, "R7 bit low ignored", {bcyc, done_seen}, 0);
        wren_bit = 1;
        run_cmd(2'b11, 5'd5);
        chk(cksum == e, "R7 page 5 intact", cksum, e);
    endtask

    task automatic t_busy_ignore();
        logic [6:0] p0;
        set_ptr(7'h2A);
        p0 = host_ptr;
        @(negedge clk); cmd_valid = 1; cmd_op = 2'b10; cmd_page = 5'd9;
        @(negedge clk); cmd_valid = 0;
        repeat (5) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b01; cmd_page = 5'd9;
        host_ptr_ld = 1; host_addr = 7'h55; host_wr = 1; host_wdata = 8'h12;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 2'b00; host_ptr_ld = 0; host_wr = 0;
        host_rd = 1;
        @(negedge clk); host_rd = 0;
        wait_idle();
        chk(host_ptr == p0, "R10 pointer untouched while busy", host_ptr, p0);
        chk(done_seen, "R9 load finished", done_seen, 1);
        @(negedge clk);
        chk(busy == 0, "R9 command while busy not queued", busy, 0);
        dump_cmp(3, "R10 ram equals erased page 9");
    endtask

    task automatic t_boot();
        fill(2);
        run_cmd(2'b01, 5'd0);
        fill(0);
        do_reset();
        chk(bcyc == 129, "R12 boot busy after store", bcyc, 129);
        begin
            int bad = 0;
            for (int k = 0; k < 16; k++)
                if (cfg_regs[k*8 +: 8] !== pat_b(k)) bad++;
            chk(bad == 0, "R6 cfg_regs from page 0 bank 0", cfg_regs[7:0], pat_b(0));
        end
        chk(host_ptr == 0, "R6 pointer reset", host_ptr, 0);
        dump_cmp(2, "R6 ram loaded from page 0");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_linear();
        t_wrap();
        t_store_load();
        t_checksum();
        t_protect();
        t_busy_ignore();
        t_boot();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule